// File: doc/BRIEF.md
# Critical-Word-First Linefill Buffer

This block runs one cache line fill at a time after a cacheable read miss. The line is four 64-bit doublewords. When a CPU read misses in the tag lookup and no fill is in progress, the block asks the bus for the line, naming the doubleword that missed. The bus returns the doublewords in wrap-around order: the missed doubleword first, then the next index, and so on modulo the line length. Each returning doubleword is stored in a small fill buffer. The missed (critical) doubleword is passed to the CPU in the same cycle it arrives.

While the fill is in progress, the CPU may keep issuing reads. A read to another line that hits in the tag array is answered at once from the data array. A read to the line being filled is answered from the buffer if its doubleword is already there. If that doubleword is arriving on the bus in the current cycle, it is forwarded directly, but only when streaming is enabled. Otherwise the read waits. A second miss waits until the current fill is done.

One cycle after the last doubleword arrives, the whole line is written into the cache data array in a single cycle, marked valid and clean. The unit then becomes idle again.

Top module: `cwf_linefill`

## Requirements
- R1: With no fill in progress, a CPU read with `tag_hit` low raises `bus_req` in the same cycle, with `bus_addr` equal to `cpu_addr`, and the read stalls. `bus_req` is never raised while a fill is in progress.
- R2: The k-th returning doubleword (k = 0..3, counted from the first doubleword after `bus_req`) belongs to line index (critical index + k) mod 4. The critical index is the low two bits of the address that missed.
- R3: The first doubleword of a fill is returned on `cpu_rdata` with `cpu_rvalid` high in the cycle it arrives, whatever the value of `stream_en`.
- R4: A later doubleword that arrives while a read for it is pending is forwarded in the same cycle only when `stream_en` is 1. With `stream_en` at 0, the read stalls that cycle and completes in the next cycle from the buffer.
- R5: During a fill, a read to the filling line whose doubleword has already been received completes in the same cycle with the buffered data.
- R6: During a fill, a read to the filling line whose doubleword has not been received and is not being forwarded keeps `cpu_stall` high and `cpu_rvalid` low.
- R7: After the critical doubleword has arrived, a read to another line with `tag_hit` high completes in the same cycle with `arr_rdata`.
- R8: A miss to another line during a fill stalls until the line has been installed. Its `bus_req` is raised in the first cycle after the install cycle.
- R9: In the cycle after the fourth doubleword arrives, `arr_wr_en` is high for exactly one cycle. In that cycle `arr_wr_line` gives the line address, `arr_wr_valid` is 1 and `arr_wr_dirty` is 0. The unit is idle in the following cycle.
- R10: After reset, the unit is idle: `cpu_rvalid`, `cpu_stall`, `bus_req` and `arr_wr_en` are low while no read is presented.
- R11: With no fill in progress, a read with `tag_hit` high completes in the same cycle with `arr_rdata`.
- R12: `arr_wr_data` holds the doubleword for line index i at bits [64*i+63 : 64*i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stream_en | input | 1 | Allows later doublewords to be forwarded while they arrive |
| cpu_req | input | 1 | CPU read request, held until served |
| cpu_addr | input | ADDR_W | Doubleword address; the low 2 bits are the index within the line |
| tag_hit | input | 1 | Tag lookup result for `cpu_addr` in the current cycle |
| arr_rdata | input | DW_W | Data-array read data for a tag hit |
| cpu_rvalid | output | 1 | Read completes this cycle |
| cpu_rdata | output | DW_W | Read data |
| cpu_stall | output | 1 | Read is presented but not served this cycle |
| bus_req | output | 1 | Start-of-fill pulse to the bus |
| bus_addr | output | ADDR_W | Address of the critical doubleword |
| bus_beat_valid | input | 1 | A fill doubleword arrives this cycle |
| bus_beat_data | input | DW_W | Arriving doubleword |
| arr_wr_en | output | 1 | Install the completed line into the data array |
| arr_wr_line | output | ADDR_W-2 | Line address being installed |
| arr_wr_data | output | 4*DW_W | Full line, index i in slice i |
| arr_wr_valid | output | 1 | Valid state for the installed line |
| arr_wr_dirty | output | 1 | Dirty state for the installed line |

## Verification
The checks assume that the bus delivers exactly four doublewords per request, and only after that request. They also assume that the CPU keeps its missing read, unchanged, on the port until it is served, and that `tag_hit` is never high for the line being filled. The stimulus is a scripted sequence of cycles that follows these rules. A bus model delivers each fill's doublewords in wrap-around order, and the CPU is held on each stalled address until the reference model says it has been served. Streaming is exercised both on and off, with gaps and with back-to-back arrivals, and with the critical index at 0, 2 and 3.

// File: rtl/cwf_pkg.sv
package cwf_pkg;

    localparam int unsigned CWF_ADDR_W = 29;
    localparam int unsigned CWF_DW_W   = 64;
    localparam int unsigned CWF_NUM_DW = 4;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_FILL,
        FS_INSTALL
    } fill_state_e;

    typedef enum logic [1:0] {
        RS_NONE,
        RS_BUF,
        RS_BUS,
        RS_ARRAY
    } resp_src_e;

    typedef struct packed {
        resp_src_e src;
        logic      start;
    } resp_dec_t;

endpackage

// File: rtl/cwf_fill_ctrl.sv
module cwf_fill_ctrl
    import cwf_pkg::*;
#(
    parameter int unsigned LINE_W = 27,
    parameter int unsigned IDX_W  = 2,
    parameter int unsigned NUM_DW = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LINE_W-1:0] start_line,
    input  logic [IDX_W-1:0]  start_idx,
    input  logic              beat_valid,
    output fill_state_e       state,
    output logic [LINE_W-1:0] fill_line,
    output logic [IDX_W-1:0]  beat_idx,
    output logic              first_beat,
    output logic [NUM_DW-1:0] rcvd_mask,
    output logic              buf_we
);

    localparam logic [IDX_W-1:0] LAST_CNT = IDX_W'(NUM_DW - 1);

    fill_state_e       state_q;
    logic [IDX_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  crit_q;
    logic [LINE_W-1:0] line_q;
    logic [NUM_DW-1:0] mask_q;

    // wrap-around order: index advances modulo the line length
    assign beat_idx   = crit_q + cnt_q;
    assign first_beat = (cnt_q == '0);
    assign buf_we     = beat_valid && (state_q == FS_FILL);
    assign state      = state_q;
    assign fill_line  = line_q;
    assign rcvd_mask  = mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FS_IDLE;
            cnt_q   <= '0;
            crit_q  <= '0;
            line_q  <= '0;
            mask_q  <= '0;
        end else begin
            unique case (state_q)
                FS_IDLE: begin
                    if (start) begin
                        state_q <= FS_FILL;
                        line_q  <= start_line;
                        crit_q  <= start_idx;
                        cnt_q   <= '0;
                        mask_q  <= '0;
                    end
                end
                FS_FILL: begin
                    if (beat_valid) begin
                        mask_q[beat_idx] <= 1'b1;
                        cnt_q            <= cnt_q + 1'b1;
                        if (cnt_q == LAST_CNT) begin
                            state_q <= FS_INSTALL;
                        end
                    end
                end
                FS_INSTALL: begin
                    state_q <= FS_IDLE;
                    mask_q  <= '0;
                end
                default: state_q <= FS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cwf_fill_buf.sv
module cwf_fill_buf #(
    parameter int unsigned DW_W   = 64,
    parameter int unsigned NUM_DW = 4,
    parameter int unsigned IDX_W  = 2
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [DW_W-1:0]          wr_data,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic [DW_W-1:0]          rd_data,
    output logic [NUM_DW*DW_W-1:0]   line_data
);

    for (genvar i = 0; i < NUM_DW; i++) begin : g_slot
        logic [DW_W-1:0] q;
        always_ff @(posedge clk) begin
            if (we && (wr_idx == IDX_W'(i))) begin
                q <= wr_data;
            end
        end
        assign line_data[i*DW_W +: DW_W] = q;
    end

    assign rd_data = line_data[rd_idx*DW_W +: DW_W];

endmodule

// File: rtl/cwf_resp_sel.sv
module cwf_resp_sel
    import cwf_pkg::*;
#(
    parameter int unsigned LINE_W = 27,
    parameter int unsigned IDX_W  = 2,
    parameter int unsigned NUM_DW = 4
) (
    input  logic              cpu_req,
    input  logic [LINE_W-1:0] cpu_line,
    input  logic [IDX_W-1:0]  cpu_idx,
    input  logic              tag_hit,
    input  logic              stream_en,
    input  fill_state_e       state,
    input  logic [LINE_W-1:0] fill_line,
    input  logic [NUM_DW-1:0] rcvd_mask,
    input  logic              beat_valid,
    input  logic [IDX_W-1:0]  beat_idx,
    input  logic              first_beat,
    output resp_dec_t         dec
);

    logic fill_busy;
    logic same_line;
    logic beat_here;
    logic may_forward;
    logic crit_done;

    assign fill_busy   = (state != FS_IDLE);
    assign same_line   = fill_busy && (cpu_line == fill_line);
    assign beat_here   = beat_valid && (state == FS_FILL) && (beat_idx == cpu_idx);
    assign may_forward = first_beat || stream_en;
    assign crit_done   = |rcvd_mask;

    always_comb begin
        dec.src   = RS_NONE;
        dec.start = 1'b0;
        if (cpu_req) begin
            if (same_line) begin
                if (rcvd_mask[cpu_idx]) begin
                    dec.src = RS_BUF;
                end else if (beat_here && may_forward) begin
                    dec.src = RS_BUS;
                end
            end else if (fill_busy) begin
                if (tag_hit && crit_done) begin
                    dec.src = RS_ARRAY;
                end
            end else if (tag_hit) begin
                dec.src = RS_ARRAY;
            end else begin
                dec.start = 1'b1;
            end
        end
    end

endmodule

// File: rtl/cwf_linefill.sv
module cwf_linefill
    import cwf_pkg::*;
#(
    parameter int unsigned ADDR_W = CWF_ADDR_W,
    parameter int unsigned DW_W   = CWF_DW_W,
    parameter int unsigned NUM_DW = CWF_NUM_DW
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 stream_en,
    input  logic                                 cpu_req,
    input  logic [ADDR_W-1:0]                    cpu_addr,
    input  logic                                 tag_hit,
    input  logic [DW_W-1:0]                      arr_rdata,
    output logic                                 cpu_rvalid,
    output logic [DW_W-1:0]                      cpu_rdata,
    output logic                                 cpu_stall,
    output logic                                 bus_req,
    output logic [ADDR_W-1:0]                    bus_addr,
    input  logic                                 bus_beat_valid,
    input  logic [DW_W-1:0]                      bus_beat_data,
    output logic                                 arr_wr_en,
    output logic [ADDR_W-$clog2(NUM_DW)-1:0]     arr_wr_line,
    output logic [NUM_DW*DW_W-1:0]               arr_wr_data,
    output logic                                 arr_wr_valid,
    output logic                                 arr_wr_dirty
);

    localparam int unsigned IDX_W  = $clog2(NUM_DW);
    localparam int unsigned LINE_W = ADDR_W - IDX_W;

    logic [LINE_W-1:0] cpu_line;
    logic [IDX_W-1:0]  cpu_idx;
    fill_state_e       state;
    logic [LINE_W-1:0] fill_line;
    logic [IDX_W-1:0]  beat_idx;
    logic              first_beat;
    logic [NUM_DW-1:0] rcvd_mask;
    logic              buf_we;
    logic [DW_W-1:0]   buf_rdata;
    resp_dec_t         dec;

    assign cpu_line = cpu_addr[ADDR_W-1:IDX_W];
    assign cpu_idx  = cpu_addr[IDX_W-1:0];

    cwf_fill_ctrl #(
        .LINE_W (LINE_W),
        .IDX_W  (IDX_W),
        .NUM_DW (NUM_DW)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (dec.start),
        .start_line (cpu_line),
        .start_idx  (cpu_idx),
        .beat_valid (bus_beat_valid),
        .state      (state),
        .fill_line  (fill_line),
        .beat_idx   (beat_idx),
        .first_beat (first_beat),
        .rcvd_mask  (rcvd_mask),
        .buf_we     (buf_we)
    );

    cwf_fill_buf #(
        .DW_W   (DW_W),
        .NUM_DW (NUM_DW),
        .IDX_W  (IDX_W)
    ) u_buf (
        .clk       (clk),
        .we        (buf_we),
        .wr_idx    (beat_idx),
        .wr_data   (bus_beat_data),
        .rd_idx    (cpu_idx),
        .rd_data   (buf_rdata),
        .line_data (arr_wr_data)
    );

    cwf_resp_sel #(
        .LINE_W (LINE_W),
        .IDX_W  (IDX_W),
        .NUM_DW (NUM_DW)
    ) u_sel (
        .cpu_req    (cpu_req),
        .cpu_line   (cpu_line),
        .cpu_idx    (cpu_idx),
        .tag_hit    (tag_hit),
        .stream_en  (stream_en),
        .state      (state),
        .fill_line  (fill_line),
        .rcvd_mask  (rcvd_mask),
        .beat_valid (bus_beat_valid),
        .beat_idx   (beat_idx),
        .first_beat (first_beat),
        .dec        (dec)
    );

    always_comb begin
        unique case (dec.src)
            RS_BUF:   cpu_rdata = buf_rdata;
            RS_BUS:   cpu_rdata = bus_beat_data;
            RS_ARRAY: cpu_rdata = arr_rdata;
            default:  cpu_rdata = '0;
        endcase
    end

    assign cpu_rvalid   = (dec.src != RS_NONE);
    assign cpu_stall    = cpu_req && !cpu_rvalid;
    assign bus_req      = dec.start;
    assign bus_addr     = cpu_addr;
    assign arr_wr_en    = (state == FS_INSTALL);
    assign arr_wr_line  = fill_line;
    assign arr_wr_valid = arr_wr_en;
    assign arr_wr_dirty = 1'b0;

endmodule

// File: rtl/cwf_linefill_chk.sv
module cwf_linefill_chk #(
    parameter int unsigned ADDR_W = 29,
    parameter int unsigned DW_W   = 64,
    parameter int unsigned NUM_DW = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            cpu_req,
    input logic            tag_hit,
    input logic            cpu_rvalid,
    input logic [DW_W-1:0] cpu_rdata,
    input logic            cpu_stall,
    input logic            bus_req,
    input logic            bus_beat_valid,
    input logic [DW_W-1:0] bus_beat_data,
    input logic            arr_wr_en
);

    localparam int unsigned CNT_W = $clog2(NUM_DW) + 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(NUM_DW);

    logic             busy;
    logic             await_crit;
    logic [CNT_W-1:0] beats;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            await_crit <= 1'b0;
            beats      <= '0;
        end else begin
            if (bus_req) begin
                busy       <= 1'b1;
                await_crit <= 1'b1;
                beats      <= '0;
            end else begin
                if (arr_wr_en) begin
                    busy <= 1'b0;
                end
                if (bus_beat_valid) begin
                    await_crit <= 1'b0;
                    beats      <= beats + 1'b1;
                end
            end
        end
    end

    // R1: a fill only starts from a presented, stalled miss
    a_r1_req_on_miss: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> (cpu_req && !tag_hit && cpu_stall));

    // R8: never a second request while a fill is outstanding
    a_r8_single_fill: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> !busy);

    // R3: the first arriving doubleword answers the held miss at once
    a_r3_crit_forward: assert property (@(posedge clk) disable iff (rst)
        (await_crit && bus_beat_valid && cpu_req) |-> (cpu_rvalid && cpu_rdata == bus_beat_data));

    // R9: install lasts one cycle
    a_r9_one_cycle: assert property (@(posedge clk) disable iff (rst)
        arr_wr_en |=> !arr_wr_en);

    // R9: install follows the final doubleword
    a_r9_after_last: assert property (@(posedge clk) disable iff (rst)
        arr_wr_en |-> (beats == FULL_CNT && $past(bus_beat_valid)));

    // R2: doublewords only arrive inside a fill and never more than a line
    a_r2_beats_bounded: assert property (@(posedge clk) disable iff (rst)
        bus_beat_valid |-> (busy && beats < FULL_CNT));

    // R10: no install in the cycle after reset
    a_r10_reset_quiet: assert property (@(posedge clk)
        rst |=> !arr_wr_en);

endmodule

bind cwf_linefill cwf_linefill_chk #(
    .ADDR_W (ADDR_W),
    .DW_W   (DW_W),
    .NUM_DW (NUM_DW)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .cpu_req        (cpu_req),
    .tag_hit        (tag_hit),
    .cpu_rvalid     (cpu_rvalid),
    .cpu_rdata      (cpu_rdata),
    .cpu_stall      (cpu_stall),
    .bus_req        (bus_req),
    .bus_beat_valid (bus_beat_valid),
    .bus_beat_data  (bus_beat_data),
    .arr_wr_en      (arr_wr_en)
);

// File: tb/cwf_linefill_tb.sv
module cwf_linefill_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 29;
    localparam int DW_W       = 64;
    localparam int NUM_DW     = 4;
    localparam int IDX_W      = 2;
    localparam int LINE_W     = ADDR_W - IDX_W;
    localparam int LBITS      = NUM_DW * DW_W;

    logic              clk;
    logic              rst;
    logic              stream_en;
    logic              cpu_req;
    logic [ADDR_W-1:0] cpu_addr;
    logic              tag_hit;
    logic [DW_W-1:0]   arr_rdata;
    logic              cpu_rvalid;
    logic [DW_W-1:0]   cpu_rdata;
    logic              cpu_stall;
    logic              bus_req;
    logic [ADDR_W-1:0] bus_addr;
    logic              bus_beat_valid;
    logic [DW_W-1:0]   bus_beat_data;
    logic              arr_wr_en;
    logic [LINE_W-1:0] arr_wr_line;
    logic [LBITS-1:0]  arr_wr_data;
    logic              arr_wr_valid;
    logic              arr_wr_dirty;

    cwf_linefill u_dut (
        .clk            (clk),
        .rst            (rst),
        .stream_en      (stream_en),
        .cpu_req        (cpu_req),
        .cpu_addr       (cpu_addr),
        .tag_hit        (tag_hit),
        .arr_rdata      (arr_rdata),
        .cpu_rvalid     (cpu_rvalid),
        .cpu_rdata      (cpu_rdata),
        .cpu_stall      (cpu_stall),
        .bus_req        (bus_req),
        .bus_addr       (bus_addr),
        .bus_beat_valid (bus_beat_valid),
        .bus_beat_data  (bus_beat_data),
        .arr_wr_en      (arr_wr_en),
        .arr_wr_line    (arr_wr_line),
        .arr_wr_data    (arr_wr_data),
        .arr_wr_valid   (arr_wr_valid),
        .arr_wr_dirty   (arr_wr_dirty)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    // reference model state: 0 idle, 1 filling, 2 installing
    int              m_state;
    int              m_line;
    int              m_crit;
    int              m_nb;
    bit              m_have [NUM_DW];
    logic [DW_W-1:0] m_buf  [NUM_DW];
    int              checks;
    int              errors;
    bit              done;

    function automatic logic [ADDR_W-1:0] mk(int line, int idx);
        return {LINE_W'(line), IDX_W'(idx)};
    endfunction

    function automatic logic [DW_W-1:0] mem_dw(logic [ADDR_W-1:0] a);
        return {a, 3'b101, ~a, 3'b010};
    endfunction

    function automatic logic [DW_W-1:0] arr_dw(logic [ADDR_W-1:0] a);
        return {~a, 3'b110, a, 3'b001};
    endfunction

    task automatic check(string tag, string what, logic [LBITS-1:0] act, logic [LBITS-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(bit req, int line, int idx, bit hit, bit bv, bit sen, string tag);
        logic [ADDR_W-1:0] a;
        logic [DW_W-1:0]   bdata;
        logic [DW_W-1:0]   e_rd;
        logic [LBITS-1:0]  e_line;
        bit                e_rv;
        bit                e_br;
        int                bk;
        a     = mk(line, idx);
        bk    = (m_crit + m_nb) % NUM_DW;
        bdata = bv ? mem_dw(mk(m_line, bk)) : '0;
        cpu_req        = req;
        cpu_addr       = a;
        tag_hit        = hit;
        arr_rdata      = arr_dw(a);
        stream_en      = sen;
        bus_beat_valid = bv;
        bus_beat_data  = bdata;
        #1;
        e_rv = 1'b0;
        e_br = 1'b0;
        e_rd = '0;
        if (req) begin
            if (m_state != 0 && line == m_line) begin
                if (m_have[idx]) begin
                    e_rv = 1'b1;
                    e_rd = m_buf[idx];
                end else if (bv && m_state == 1 && bk == idx && (m_nb == 0 || sen)) begin
                    e_rv = 1'b1;
                    e_rd = bdata;
                end
            end else if (m_state != 0) begin
                if (hit && m_nb > 0) begin
                    e_rv = 1'b1;
                    e_rd = arr_dw(a);
                end
            end else if (hit) begin
                e_rv = 1'b1;
                e_rd = arr_dw(a);
            end else begin
                e_br = 1'b1;
            end
        end
        check(tag, "cpu_rvalid", LBITS'(cpu_rvalid), LBITS'(e_rv));
        check(tag, "cpu_stall", LBITS'(cpu_stall), LBITS'(req && !e_rv));
        if (e_rv) check(tag, "cpu_rdata", LBITS'(cpu_rdata), LBITS'(e_rd));
        check("R1", "bus_req", LBITS'(bus_req), LBITS'(e_br));
        if (e_br) check("R1", "bus_addr", LBITS'(bus_addr), LBITS'(a));
        check("R9", "arr_wr_en", LBITS'(arr_wr_en), LBITS'(m_state == 2));
        if (m_state == 2) begin
            for (int k = 0; k < NUM_DW; k++) e_line[k*DW_W +: DW_W] = m_buf[k];
            check("R9", "arr_wr_line", LBITS'(arr_wr_line), LBITS'(LINE_W'(m_line)));
            check("R9", "arr_wr_valid", LBITS'(arr_wr_valid), LBITS'(1));
            check("R9", "arr_wr_dirty", LBITS'(arr_wr_dirty), LBITS'(0));
            check("R12", "arr_wr_data", arr_wr_data, e_line);
        end
        @(posedge clk);
        if (m_state == 0) begin
            if (e_br) begin
                m_state = 1;
                m_line  = line;
                m_crit  = idx;
                m_nb    = 0;
                for (int k = 0; k < NUM_DW; k++) m_have[k] = 1'b0;
            end
        end else if (m_state == 1) begin
            if (bv) begin
                m_buf[bk]  = bdata;
                m_have[bk] = 1'b1;
                m_nb++;
                if (m_nb == NUM_DW) m_state = 2;
            end
        end else begin
            m_state = 0;
            for (int k = 0; k < NUM_DW; k++) m_have[k] = 1'b0;
        end
        @(negedge clk);
    endtask

    initial begin
        checks = 0;
        errors = 0;
        done   = 1'b0;
        m_state = 0; m_line = -1; m_crit = 0; m_nb = 0;
        for (int k = 0; k < NUM_DW; k++) begin
            m_have[k] = 1'b0;
            m_buf[k]  = '0;
        end
        rst = 1'b1;
        cpu_req = 0; cpu_addr = '0; tag_hit = 0; arr_rdata = '0;
        stream_en = 0; bus_beat_valid = 0; bus_beat_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10: quiet after reset
        cyc(0, 0, 0, 0, 0, 0, "R10");
        cyc(0, 0, 0, 0, 0, 1, "R10");
        // R11: hits with no fill
        cyc(1, 5, 1, 1, 0, 0, "R11");
        cyc(1, 9, 3, 1, 0, 0, "R11");
        // fill of line 16, critical index 2, streaming on, with gaps
        cyc(1, 16, 2, 0, 0, 1, "R1");
        cyc(1, 16, 2, 0, 0, 1, "R6");
        cyc(1, 16, 2, 0, 0, 1, "R6");
        cyc(1, 16, 2, 0, 1, 1, "R3");
        cyc(1, 16, 3, 0, 1, 1, "R4");
        cyc(1, 16, 2, 0, 0, 1, "R5");
        cyc(1, 40, 1, 1, 0, 1, "R7");
        cyc(1, 16, 1, 0, 0, 1, "R6");
        cyc(1, 16, 1, 0, 1, 1, "R6");
        cyc(1, 16, 1, 0, 1, 1, "R4");
        cyc(1, 16, 0, 0, 0, 1, "R5");
        cyc(0, 0, 0, 0, 0, 1, "R9");
        cyc(1, 16, 3, 1, 0, 1, "R11");
        // fill of line 33, critical index 0, streaming off
        cyc(1, 33, 0, 0, 0, 0, "R1");
        cyc(1, 33, 0, 0, 1, 0, "R3");
        cyc(1, 33, 1, 0, 1, 0, "R4");
        cyc(1, 33, 1, 0, 0, 0, "R4");
        cyc(1, 50, 3, 0, 1, 0, "R8");
        cyc(1, 50, 3, 0, 1, 0, "R8");
        cyc(1, 50, 3, 0, 0, 0, "R8");
        cyc(1, 50, 3, 0, 0, 0, "R8");
        // fill of line 50, critical index 3, back-to-back arrivals
        cyc(1, 50, 3, 0, 1, 0, "R3");
        cyc(0, 0, 0, 0, 1, 0, "R2");
        cyc(1, 50, 0, 0, 1, 0, "R5");
        cyc(1, 50, 2, 0, 1, 0, "R6");
        cyc(1, 50, 2, 0, 0, 0, "R5");
        cyc(0, 0, 0, 0, 0, 0, "R10");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R10 watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule